// File: doc/BRIEF.md
# Audio Link Output Frame Serializer

This block sits on the controller side of a five-wire audio codec link and turns one frame's worth of parallel content into a serial stream on the bit clock. Every frame is 256 bit clocks long. It opens with a 16-bit tag slot that tells the codec which of the following slots carry data, then twelve 20-bit slots. Slot 1 carries a command address, slot 2 carries command write data, and slots 3 and 4 carry the left and right PCM samples. Slots 5 to 12 are always sent as zero.

A frame begins when `frame_req` is sampled high on a rising edge while the block is idle, or on the edge that ends the last bit of the current frame, so frames can run back to back. All frame content is captured on that edge and stays fixed for the whole frame. The tag bits are computed from the command request and the sample valid flags. Samples of `SAMPLE_W` bits are placed at the top of their slot with zero padding below. The frame sync line is high during the tag slot and low for the rest of the frame.

Top module: `ac_frame_tx`

## Requirements
- R1: The first bit of each frame (tag bit 15) is 1 exactly when at least one of slots 1 to 4 is marked valid in that frame.
- R2: Tag bits 14, 13, 12 and 11 are the valid flags of slots 1, 2, 3 and 4. Slot 1 is valid when `cmd_req` is 1. Slot 2 is valid when `cmd_req` is 1 and `cmd_rd` is 0. Slot 3 is valid when `pcm_l_vld` is 1. Slot 4 is valid when `pcm_r_vld` is 1.
- R3: Tag bits 10 down to 0 are sent as zero.
- R4: A frame is sent as the 16-bit tag, then slots 1 to 12 at 20 bits each, 256 bits in all. Every slot is sent most significant bit first, and sample bits take slot bits 19 down to 20-`SAMPLE_W`.
- R5: When a sample is narrower than 20 bits, the low 20-`SAMPLE_W` bits of its slot are zero. The slot of an invalid sample is all zero.
- R6: Slot 1 bit 19 is `cmd_rd` (1 = read, 0 = write) and bits 18 to 12 are `cmd_idx`. The whole of slot 1 is zero when `cmd_req` is 0.
- R7: Slot 1 bits 11 down to 0 are always zero.
- R8: Slot 2 carries `cmd_data` in bits 19 to 4 with bits 3 to 0 zero on a write. It is all zero on a read or when no command is requested.
- R9: Every bit of slots 5 to 12 is zero.
- R10: `sync` is high for the 16 bit clocks of the tag slot and low for the other 240 bit clocks of the frame.
- R11: When no frame is in progress, `sdo` and `sync` are low. A request sampled while idle, or on the edge after the last frame bit, makes the first bit of the new frame appear right after that edge.
- R12: A `frame_req` seen during a frame, other than on its final edge, is ignored. Input changes after the start edge have no effect on the frame being sent.
- R13: While `rst_n` is low, `sdo` and `sync` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_req | input | 1 | Request to start a frame with the present inputs |
| cmd_req | input | 1 | A register command accompanies this frame |
| cmd_rd | input | 1 | Command direction, 1 = read, 0 = write |
| cmd_idx | input | 7 | Register index of the command |
| cmd_data | input | 16 | Write data of the command |
| pcm_l_vld | input | 1 | Left sample is valid |
| pcm_l | input | SAMPLE_W | Left sample |
| pcm_r_vld | input | 1 | Right sample is valid |
| pcm_r | input | SAMPLE_W | Right sample |
| sdo | output | 1 | Serial frame data |
| sync | output | 1 | Frame sync, high during the tag slot |

## Verification
The assertions check on every cycle the properties that depend only on position within the frame. These are the 16-clock sync pulse, the zero tag padding, the zero reserved bits of the command slot, the zero tail slots, the quiet line when idle, and the agreement of the frame-valid bit with the four slot flags that follow it. What a slot contains depends on the inputs at the start edge, so only the bench scenarios can show it. Those scenarios cover write and read commands, padded samples, back-to-back frames, a mid-frame request, and input changes during a frame that must be ignored.

// File: rtl/ac_frame_pkg.sv
package ac_frame_pkg;
   localparam int TAG_W      = 16;
   localparam int SLOT_W     = 20;
   localparam int NUM_SLOTS  = 12;
   localparam int NUM_FLAGS  = 4;
   localparam int IDX_W      = 7;
   localparam int CMD_DATA_W = 16;
   localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
   localparam int TAIL_BITS  = (NUM_SLOTS - NUM_FLAGS) * SLOT_W;
   localparam int CNT_W      = $clog2(FRAME_BITS);
endpackage

// File: rtl/ac_tag_build.sv
module ac_tag_build #(
   parameter int NFLAG = 4,
   parameter int TW    = 16
) (
   input  logic [NFLAG-1:0] slot_vld,
   output logic [TW-1:0]    tag
);
   localparam int PAD_W = TW - 1 - NFLAG;

   if (NFLAG < 1 || NFLAG > TW - 1) begin : g_bad_cfg
      $error("ac_tag_build: NFLAG out of range");
   end

   assign tag[TW-1] = |slot_vld;

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      assign tag[TW-2-i] = slot_vld[i];
   end

   if (PAD_W > 0) begin : g_pad
      assign tag[PAD_W-1:0] = '0;
   end
endmodule

// File: rtl/ac_slot_pack.sv
module ac_slot_pack #(
   parameter int IN_W = 18,
   parameter int SW   = 20
) (
   input  logic            vld,
   input  logic [IN_W-1:0] din,
   output logic [SW-1:0]   dout
);
   localparam int FILL_W = SW - IN_W;

   if (IN_W < 1 || IN_W > SW) begin : g_bad_cfg
      $error("ac_slot_pack: IN_W must lie in 1..SW");
   end

   if (FILL_W == 0) begin : g_full
      assign dout = vld ? din : '0;
   end else begin : g_padded
      assign dout = vld ? {din, {FILL_W{1'b0}}} : '0;
   end
endmodule

// File: rtl/ac_cmd_addr.sv
module ac_cmd_addr #(
   parameter int IW = 7,
   parameter int SW = 20
) (
   input  logic          vld,
   input  logic          rd,
   input  logic [IW-1:0] idx,
   output logic [SW-1:0] dout
);
   localparam int RSV_W = SW - 1 - IW;

   if (RSV_W < 0) begin : g_bad_cfg
      $error("ac_cmd_addr: index does not fit in slot");
   end

   if (RSV_W == 0) begin : g_nores
      assign dout = vld ? {rd, idx} : '0;
   end else begin : g_res
      assign dout = vld ? {rd, idx, {RSV_W{1'b0}}} : '0;
   end
endmodule

// File: rtl/ac_frame_shift.sv
module ac_frame_shift #(
   parameter int FB  = 256,
   parameter int TW  = 16,
   parameter int CW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_req,
   input  logic [FB-1:0] frame_in,
   output logic          sdo,
   output logic          sync,
   output logic          busy
);
   logic [FB-1:0] shreg;
   logic [CW-1:0] cnt;
   logic          last;
   logic          start;

   if ((1 << CW) < FB) begin : g_bad_cfg
      $error("ac_frame_shift: counter too narrow");
   end

   assign last  = busy && (cnt == CW'(FB - 1));
   assign start = start_req && (!busy || last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
         busy  <= 1'b0;
      end else if (start) begin
         shreg <= frame_in;
         cnt   <= '0;
         busy  <= 1'b1;
      end else if (busy) begin
         shreg <= {shreg[FB-2:0], 1'b0};
         if (last) begin
            cnt  <= '0;
            busy <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign sdo  = shreg[FB-1];
   assign sync = busy && (cnt < CW'(TW));
endmodule

// File: rtl/ac_frame_tx.sv
module ac_frame_tx
   import ac_frame_pkg::*;
#(
   parameter int SAMPLE_W = 18
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_req,
   input  logic                  cmd_req,
   input  logic                  cmd_rd,
   input  logic [IDX_W-1:0]      cmd_idx,
   input  logic [CMD_DATA_W-1:0] cmd_data,
   input  logic                  pcm_l_vld,
   input  logic [SAMPLE_W-1:0]   pcm_l,
   input  logic                  pcm_r_vld,
   input  logic [SAMPLE_W-1:0]   pcm_r,
   output logic                  sdo,
   output logic                  sync
);
   logic [NUM_FLAGS-1:0]  slot_vld;
   logic [TAG_W-1:0]      tag;
   logic [SLOT_W-1:0]     s_addr, s_wdat, s_left, s_right;
   logic [FRAME_BITS-1:0] frame_vec;
   logic                  busy;

   assign slot_vld = {pcm_r_vld, pcm_l_vld, cmd_req & ~cmd_rd, cmd_req};

   ac_tag_build #(.NFLAG(NUM_FLAGS), .TW(TAG_W)) u_tag (
      .slot_vld (slot_vld),
      .tag      (tag)
   );

   ac_cmd_addr #(.IW(IDX_W), .SW(SLOT_W)) u_addr (
      .vld  (slot_vld[0]),
      .rd   (cmd_rd),
      .idx  (cmd_idx),
      .dout (s_addr)
   );

   ac_slot_pack #(.IN_W(CMD_DATA_W), .SW(SLOT_W)) u_wdat (
      .vld  (slot_vld[1]),
      .din  (cmd_data),
      .dout (s_wdat)
   );

   ac_slot_pack #(.IN_W(SAMPLE_W), .SW(SLOT_W)) u_left (
      .vld  (slot_vld[2]),
      .din  (pcm_l),
      .dout (s_left)
   );

   ac_slot_pack #(.IN_W(SAMPLE_W), .SW(SLOT_W)) u_right (
      .vld  (slot_vld[3]),
      .din  (pcm_r),
      .dout (s_right)
   );

   assign frame_vec = {tag, s_addr, s_wdat, s_left, s_right, {TAIL_BITS{1'b0}}};

   ac_frame_shift #(.FB(FRAME_BITS), .TW(TAG_W), .CW(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (frame_req),
      .frame_in  (frame_vec),
      .sdo       (sdo),
      .sync      (sync),
      .busy      (busy)
   );
endmodule

// File: rtl/ac_frame_tx_chk.sv
module ac_frame_tx_chk
   import ac_frame_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic sdo,
   input logic sync,
   input logic busy
);
   logic [4:0] hi_run;
   logic [7:0] pos;
   logic       first_bit;
   logic       any_rest;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run    <= '0;
         pos       <= '0;
         first_bit <= 1'b0;
         any_rest  <= 1'b0;
      end else begin
         hi_run <= sync ? hi_run + 1'b1 : '0;
         if (sync && hi_run == 5'd0)         pos <= 8'd1;
         else if (pos != 8'd0 && pos != 8'd255) pos <= pos + 1'b1;
         else                                 pos <= 8'd0;
         if (sync && hi_run == 5'd0) begin
            first_bit <= sdo;
            any_rest  <= 1'b0;
         end else if (sync && hi_run <= 5'd4) begin
            any_rest  <= any_rest | sdo;
         end
      end
   end

   // R1
   frame_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync && hi_run == 5'd5) |-> (first_bit == any_rest));

   // R3
   tag_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync && hi_run >= 5'd5) |-> !sdo);

   // R7
   cmd_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos >= 8'd24 && pos <= 8'd35) |-> !sdo);

   // R9
   tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos >= 8'd96) |-> !sdo);

   // R10
   sync_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync |-> (hi_run < 5'd16));

   // R10
   sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync) |-> (hi_run == 5'd16));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sdo && !sync));
endmodule

bind ac_frame_tx ac_frame_tx_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .sdo   (sdo),
   .sync  (sync),
   .busy  (busy)
);

// File: tb/ac_frame_tx_tb.sv
module ac_frame_tx_tb;
   localparam int CLK_P = 10;
   localparam int SW    = 18;

   typedef struct {
      logic sdo;
      logic sync;
      int   req;
      int   idx;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_req = 1'b0;
   logic          cmd_req = 1'b0, cmd_rd = 1'b0;
   logic [6:0]    cmd_idx = '0;
   logic [15:0]   cmd_data = '0;
   logic          pcm_l_vld = 1'b0, pcm_r_vld = 1'b0;
   logic [SW-1:0] pcm_l = '0, pcm_r = '0;
   logic          sdo, sync;

   int    n_run = 0, n_fail = 0;
   item_t exp_q[$];
   bit    done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ac_frame_tx #(.SAMPLE_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_req(frame_req),
      .cmd_req(cmd_req), .cmd_rd(cmd_rd), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
      .pcm_l_vld(pcm_l_vld), .pcm_l(pcm_l), .pcm_r_vld(pcm_r_vld), .pcm_r(pcm_r),
      .sdo(sdo), .sync(sync)
   );

   // Expected frame from the requirements (R1, R2, R4, R5, R6, R8)
   function automatic logic [255:0] exp_frame(bit cr, bit rd, logic [6:0] idx,
         logic [15:0] d, bit lv, logic [SW-1:0] l, bit rv, logic [SW-1:0] r);
      logic [15:0] tag;
      logic [19:0] s1, s2, s3, s4;
      tag = {(cr | lv | rv), cr, cr & ~rd, lv, rv, 11'b0};
      s1  = cr ? {rd, idx, 12'b0} : 20'b0;
      s2  = (cr && !rd) ? {d, 4'b0} : 20'b0;
      s3  = lv ? {l, 2'b0} : 20'b0;
      s4  = rv ? {r, 2'b0} : 20'b0;
      return {tag, s1, s2, s3, s4, 160'b0};
   endfunction

   // Which requirement a bit position belongs to
   function automatic int req_of(int i);
      int off;
      if (i == 0)  return 1;   // R1
      if (i < 5)   return 2;   // R2
      if (i < 16)  return 3;   // R3
      if (i < 24)  return 6;   // R6
      if (i < 36)  return 7;   // R7
      if (i < 56)  return 8;   // R8
      if (i < 96) begin
         off = (i - 56) % 20;
         return (off < SW) ? 4 : 5;   // R4 data bits, R5 padding
      end
      return 9;                // R9
   endfunction

   task automatic send_frame(bit cr, bit rd, logic [6:0] idx, logic [15:0] d,
         bit lv, logic [SW-1:0] l, bit rv, logic [SW-1:0] r, int ovr);
      logic [255:0] f;
      @(negedge clk);
      cmd_req = cr; cmd_rd = rd; cmd_idx = idx; cmd_data = d;
      pcm_l_vld = lv; pcm_l = l; pcm_r_vld = rv; pcm_r = r;
      frame_req = 1'b1;
      f = exp_frame(cr, rd, idx, d, lv, l, rv, r);
      @(posedge clk);
      for (int i = 0; i < 256; i++) begin
         item_t it;
         it.sdo  = f[255 - i];
         it.sync = (i < 16);
         it.req  = (ovr != 0) ? ovr : req_of(i);
         it.idx  = i;
         exp_q.push_back(it);
      end
      @(negedge clk);
      frame_req = 1'b0;
   endtask

   // Monitor: compare one expected bit per clock, idle line otherwise (R11)
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && !done) begin
            n_run++;
            if (exp_q.size() > 0) begin
               item_t it;
               it = exp_q.pop_front();
               if (sdo !== it.sdo) begin
                  n_fail++;
                  $display("FAIL R%0d bit %0d: sdo=%b expected %b", it.req, it.idx, sdo, it.sdo);
               end else if (sync !== it.sync) begin
                  n_fail++;
                  $display("FAIL R10 bit %0d: sync=%b expected %b", it.idx, sync, it.sync);
               end
            end else if (sdo !== 1'b0 || sync !== 1'b0) begin
               n_fail++;
               $display("FAIL R11 idle: sdo=%b sync=%b expected 0 0", sdo, sync);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R13: outputs low in reset
      repeat (3) @(negedge clk);
      n_run++;
      if (sdo !== 1'b0 || sync !== 1'b0) begin
         n_fail++;
         $display("FAIL R13 reset: sdo=%b sync=%b expected 0 0", sdo, sync);
      end
      rst_n = 1'b1;
      repeat (4) @(posedge clk);

      // Empty frame: frame-valid clear (R1)
      send_frame(0, 0, 7'h00, 16'h0000, 0, '0, 0, '0, 0);
      repeat (255) @(posedge clk);
      repeat (5) @(posedge clk);

      // Write command with left sample (R2, R4, R5, R6, R8)
      send_frame(1, 0, 7'h2A, 16'hBEEF, 1, 18'h2ABCD, 0, '0, 0);
      repeat (255) @(posedge clk);
      repeat (3) @(posedge clk);

      // Read command with right sample, then a back-to-back frame (R11)
      send_frame(1, 1, 7'h7F, 16'hFFFF, 0, '0, 1, 18'h3FFFF, 0);
      repeat (255) @(posedge clk);
      send_frame(0, 0, 7'h55, 16'h1234, 1, 18'h00001, 1, 18'h20000, 11);
      repeat (255) @(posedge clk);
      repeat (4) @(posedge clk);

      // R12: mid-frame request and input changes are ignored
      send_frame(1, 0, 7'h01, 16'h8001, 1, 18'h15555, 1, 18'h0AAAA, 12);
      repeat (30) @(negedge clk);
      cmd_rd = 1'b1; cmd_idx = 7'h7E; cmd_data = 16'h0F0F;
      pcm_l_vld = 1'b0; pcm_r = 18'h3C3C3; frame_req = 1'b1;
      @(negedge clk);
      frame_req = 1'b0;
      while (exp_q.size() > 0) @(negedge clk);
      repeat (8) @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule